// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block carries out 32-bit multiplication and division over many cycles and keeps the outcome in a dedicated pair of result registers, HI and LO. A one-cycle start pulse carries a function code and two operands. The unit then runs a radix-2 engine (shift-add for products, restoring subtraction for quotients) and raises a busy flag until the result is committed. A multiply leaves the 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI.

Software reads the pair back through a read port that takes the move-from-HI or move-from-LO function code. If a read arrives while an operation is still in flight, the unit raises a stall until the result lands. The read then returns the fresh value in the same cycle that the stall drops. Operations are signed or unsigned by function code. Division by zero does not trap: it produces a fixed, documented result.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, op_busy and rd_stall are 0, and both HI and LO read back as zero.
- R2: A start is accepted only while idle and only with one of the arithmetic codes: 6'b011000 signed multiply, 6'b011001 unsigned multiply, 6'b011010 signed divide, 6'b011011 unsigned divide. op_busy then rises at the next clock edge and stays high for exactly 33 cycles.
- R3: Signed multiply treats both operands as two's complement. HI receives bits 63:32 of the 64-bit product and LO receives bits 31:0.
- R4: Unsigned multiply treats both operands as unsigned and splits the 64-bit product the same way: upper half in HI, lower half in LO.
- R5: Signed divide puts the quotient, truncated toward zero, in LO. It puts the remainder in HI, and the remainder carries the sign of the dividend. Dividing the most negative value by -1 gives the quotient 32'h80000000 and the remainder 0.
- R6: Unsigned divide puts the unsigned quotient in LO and the unsigned remainder in HI.
- R7: With a zero divisor, both divide codes set LO to 32'hFFFFFFFF and HI to the unmodified dividend.
- R8: While idle, a read with rd_req high returns HI on rd_data for code 6'b010000 and LO for code 6'b010010, in the same cycle. Any other read code returns 0 and never stalls.
- R9: A read with a valid read code while op_busy is high holds rd_stall high for every busy cycle. In the first cycle after busy drops, rd_stall is low and rd_data shows the new result.
- R10: A start pulse that arrives while op_busy is high is ignored. The running operation completes with its original operands and code.
- R11: A start pulse with a non-arithmetic code while idle is ignored: op_busy stays low and HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Start pulse for an arithmetic operation |
| op_code | input | 6 | Function code of the operation |
| op_a | input | 32 | First operand (multiplicand or dividend) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| op_busy | output | 1 | High while an operation is running |
| rd_req | input | 1 | Read request for the result pair |
| rd_code | input | 6 | Read function code selecting HI or LO |
| rd_stall | output | 1 | Read must wait because the engine is busy |
| rd_data | output | 32 | Selected result register |

## Verification
The assertions assume that op_code, op_a and op_b are meaningful only in the cycle where op_start is high and the unit is idle, and that rd_code stays steady for as long as rd_req is held. The stimulus honours this. It changes operands only at the pulse. While a result is pending, it keeps the read request fixed on the LO code and switches to the HI code only after the stall has dropped. Deliberate intrusions (a start during busy, a start with a read code while idle, a read with an unknown code) are placed so that the properties still describe the expected outcome rather than being silenced.

// File: rtl/muldiv_hilo_pkg.sv
package muldiv_hilo_pkg;

  localparam logic [5:0] FN_MULT  = 6'b011000;
  localparam logic [5:0] FN_MULTU = 6'b011001;
  localparam logic [5:0] FN_DIV   = 6'b011010;
  localparam logic [5:0] FN_DIVU  = 6'b011011;
  localparam logic [5:0] FN_MFHI  = 6'b010000;
  localparam logic [5:0] FN_MFLO  = 6'b010010;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic is_div;
    logic is_signed;
  } op_cfg_t;

  function automatic logic is_arith(input logic [5:0] f);
    return (f == FN_MULT) || (f == FN_MULTU) || (f == FN_DIV) || (f == FN_DIVU);
  endfunction

  function automatic op_cfg_t decode_cfg(input logic [5:0] f);
    op_cfg_t c;
    c.is_div    = f[1];
    c.is_signed = ~f[0];
    return c;
  endfunction

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [5:0]   code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output op_cfg_t      cfg,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_rem,
  output logic         b_zero
);

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    cfg      = decode_cfg(code);
    mag_a    = magnitude(a, cfg.is_signed);
    mag_b    = magnitude(b, cfg.is_signed);
    neg_main = cfg.is_signed & (a[W-1] ^ b[W-1]);
    neg_rem  = cfg.is_signed & a[W-1];
    b_zero   = (b == '0);
  end

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine
  import muldiv_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         ld_div,
  input  logic [W-1:0] ld_a,
  input  logic [W-1:0] ld_b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  eng_state_t     state;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   b_q;
  logic           div_q;
  logic [2*W-1:0] nxt;

  // One shift-add step: conditionally add the multiplicand, then shift right.
  function automatic logic [2*W-1:0] mul_step(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                              input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, hi} + (lo[0] ? {1'b0, m} : '0);
    return {sum[W:1], sum[0], lo[W-1:1]};
  endfunction

  // One restoring step: shift the next dividend bit in, try a subtraction.
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                              input logic [W-1:0] d);
    logic [W:0] rsh;
    logic [W:0] diff;
    rsh  = {hi, lo[W-1]};
    diff = rsh - {1'b0, d};
    if (!diff[W]) return {diff[W-1:0], lo[W-2:0], 1'b1};
    else          return {rsh[W-1:0], lo[W-2:0], 1'b0};
  endfunction

  always_comb begin
    if (div_q) nxt = div_step(acc_hi, acc_lo, b_q);
    else       nxt = mul_step(acc_hi, acc_lo, b_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      b_q    <= '0;
      div_q  <= 1'b0;
      acc_hi <= '0;
      acc_lo <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (load) begin
          state  <= S_RUN;
          cnt    <= '0;
          b_q    <= ld_b;
          div_q  <= ld_div;
          acc_hi <= '0;
          acc_lo <= ld_a;
        end
        S_RUN: begin
          {acc_hi, acc_lo} <= nxt;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIX;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign fin  = (state == S_FIX);

endmodule

// File: rtl/muldiv_resreg.sv
module muldiv_resreg
  import muldiv_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  op_cfg_t      ld_cfg,
  input  logic         ld_neg_main,
  input  logic         ld_neg_rem,
  input  logic         ld_b_zero,
  input  logic [W-1:0] ld_raw_a,
  input  logic         fin,
  input  logic         busy,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic         rd_req,
  input  logic [5:0]   rd_code,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic         rd_stall,
  output logic [W-1:0] rd_data
);

  op_cfg_t        cfg_q;
  logic           neg_main_q, neg_rem_q, zero_q;
  logic [W-1:0]   raw_a_q;
  logic [2*W-1:0] res;

  function automatic logic [W-1:0] cond_neg(input logic [W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*W-1:0] cond_neg2(input logic [2*W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  // Sign fix-up and divide-by-zero override, committed on the final cycle.
  always_comb begin
    if (cfg_q.is_div && zero_q)
      res = {raw_a_q, {W{1'b1}}};
    else if (cfg_q.is_div)
      res = {cond_neg(acc_hi, neg_rem_q), cond_neg(acc_lo, neg_main_q)};
    else
      res = cond_neg2({acc_hi, acc_lo}, neg_main_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      zero_q     <= 1'b0;
      raw_a_q    <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      if (load) begin
        cfg_q      <= ld_cfg;
        neg_main_q <= ld_neg_main;
        neg_rem_q  <= ld_neg_rem;
        zero_q     <= ld_b_zero;
        raw_a_q    <= ld_raw_a;
      end
      if (fin) {hi_q, lo_q} <= res;
    end
  end

  logic want_hi, want_lo;
  assign want_hi  = rd_req && (rd_code == FN_MFHI);
  assign want_lo  = rd_req && (rd_code == FN_MFLO);
  assign rd_stall = (want_hi || want_lo) && busy;

  always_comb begin
    if (busy)         rd_data = '0;
    else if (want_hi) rd_data = hi_q;
    else if (want_lo) rd_data = lo_q;
    else              rd_data = '0;
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_start,
  input  logic [5:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         op_busy,
  input  logic         rd_req,
  input  logic [5:0]   rd_code,
  output logic         rd_stall,
  output logic [W-1:0] rd_data
);

  op_cfg_t      cfg;
  logic [W-1:0] mag_a, mag_b;
  logic         neg_main, neg_rem, b_zero;
  logic         accept, fin;
  logic [W-1:0] acc_hi, acc_lo, hi_q, lo_q;

  assign accept = op_start && !op_busy && is_arith(op_code);

  muldiv_prep #(.W(W)) u_prep (
    .code(op_code), .a(op_a), .b(op_b), .cfg(cfg), .mag_a(mag_a), .mag_b(mag_b),
    .neg_main(neg_main), .neg_rem(neg_rem), .b_zero(b_zero)
  );

  muldiv_engine #(.W(W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_div(cfg.is_div), .ld_a(mag_a), .ld_b(mag_b),
    .busy(op_busy), .fin(fin), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  muldiv_resreg #(.W(W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_cfg(cfg), .ld_neg_main(neg_main),
    .ld_neg_rem(neg_rem), .ld_b_zero(b_zero), .ld_raw_a(op_a), .fin(fin), .busy(op_busy),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .rd_req(rd_req), .rd_code(rd_code),
    .hi_q(hi_q), .lo_q(lo_q), .rd_stall(rd_stall), .rd_data(rd_data)
  );

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk
  import muldiv_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_start,
  input logic [5:0]   op_code,
  input logic         op_busy,
  input logic         accept,
  input logic         fin,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         rd_req,
  input logic [5:0]   rd_code,
  input logic         rd_stall
);

  localparam int CW = $clog2(W + 2) + 1;
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_len <= '0;
    else if (op_busy) busy_len <= busy_len + 1'b1;
    else              busy_len <= '0;
  end

  a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> op_busy);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy) |-> (busy_len == CW'(W + 1)));

  a_r9_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && rd_req && (rd_code == FN_MFHI || rd_code == FN_MFLO)) |-> rd_stall);

  a_r9_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_busy |-> !rd_stall);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !fin) |=> (op_busy && $stable(hi_q) && $stable(lo_q)));

  a_r11_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && op_start && !is_arith(op_code)) |=> (!op_busy && $stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code), .op_busy(op_busy),
  .accept(accept), .fin(fin), .hi_q(hi_q), .lo_q(lo_q), .rd_req(rd_req),
  .rd_code(rd_code), .rd_stall(rd_stall)
);

// File: tb/tb_muldiv_hilo.sv
`timescale 1ns/1ps
module tb_muldiv_hilo;
  import muldiv_hilo_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_busy;
  logic        rd_req = 1'b0;
  logic [5:0]  rd_code = '0;
  logic        rd_stall;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [31:0] last_hi = '0, last_lo = '0;

  always #2 clk = ~clk;

  muldiv_hilo dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code), .op_a(op_a),
    .op_b(op_b), .op_busy(op_busy), .rd_req(rd_req), .rd_code(rd_code),
    .rd_stall(rd_stall), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result computed from the requirement text alone.
  function automatic exp_t model(input logic [5:0] code, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    longint sa, sb2, sq, sr;
    longint unsigned ua, ub, up;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb2 = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (code)
      FN_MULT:  begin p = 64'(sa * sb2); e.hi = p[63:32]; e.lo = p[31:0]; e.tag = "R3"; end
      FN_MULTU: begin up = ua * ub; e.hi = up[63:32]; e.lo = up[31:0]; e.tag = "R4"; end
      FN_DIV: begin
        if (b == 0) begin e.hi = a; e.lo = '1; e.tag = "R7"; end
        else begin
          sq = sa / sb2; sr = sa % sb2;
          e.lo = sq[31:0]; e.hi = sr[31:0]; e.tag = "R5";
        end
      end
      default: begin
        if (b == 0) begin e.hi = a; e.lo = '1; e.tag = "R7"; end
        else begin e.lo = 32'(ua / ub); e.hi = 32'(ua % ub); e.tag = "R6"; end
      end
    endcase
    return e;
  endfunction

  // Driver: pushes the expectation, pulses start, optionally intrudes while busy.
  task automatic issue(input logic [5:0] code, input logic [31:0] a, input logic [31:0] b,
                       input bit intrude);
    @(negedge clk);
    sb.push_back(model(code, a, b));
    op_start = 1'b1; op_code = code; op_a = a; op_b = b;
    @(negedge clk);
    op_start = 1'b0;
    if (intrude) begin
      // R10: a start during busy with other code and operands must be ignored
      repeat (3) @(negedge clk);
      op_start = 1'b1; op_code = FN_MULTU; op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
      repeat (2) @(negedge clk);
      op_start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: holds a LO read through the stall, then compares both registers.
  initial begin
    int  stall_cnt;
    bit  seen_busy;
    exp_t e;
    stall_cnt = 0;
    seen_busy = 0;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        rd_req = 1'b1; rd_code = FN_MFLO;
        #0.5;
        if (op_busy) begin
          seen_busy = 1;
          stall_cnt++;
          if (!rd_stall) check(0, "R9 stall while busy", 64'(rd_stall), 64'd1);
        end else if (seen_busy) begin
          e = sb[0];
          check(!rd_stall, "R9 stall drops", 64'(rd_stall), 64'd0);
          check(rd_data == e.lo, {e.tag, " LO"}, 64'(rd_data), 64'(e.lo));
          rd_code = FN_MFHI;
          #0.5;
          check(rd_data == e.hi, {e.tag, " HI"}, 64'(rd_data), 64'(e.hi));
          check(stall_cnt == 33, "R2 busy length", 64'(stall_cnt), 64'd33);
          last_hi = e.hi; last_lo = e.lo;
          rd_req = 1'b0;
          seen_busy = 0;
          stall_cnt = 0;
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic idle_read(input logic [5:0] code, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_req = 1'b1; rd_code = code;
    #0.5;
    check(rd_data == exp && !rd_stall, tag, {31'b0, rd_stall, rd_data}, 64'(exp));
    rd_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1: reset state
    check(op_busy == 0 && rd_stall == 0, "R1 busy/stall", {op_busy, rd_stall}, 0);
    idle_read(FN_MFHI, 32'h0, "R1 HI zero");
    idle_read(FN_MFLO, 32'h0, "R1 LO zero");

    // R3 signed multiply
    issue(FN_MULT, 32'd7, -32'sd3, 0);
    issue(FN_MULT, -32'sd5, -32'sd6, 0);
    issue(FN_MULT, 32'h8000_0000, 32'h8000_0000, 0);
    issue(FN_MULT, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
    // R4 unsigned multiply
    issue(FN_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    issue(FN_MULTU, 32'h1234_5678, 32'h9ABC_DEF0, 0);
    // R5 signed divide
    issue(FN_DIV, -32'sd7, 32'd2, 0);
    issue(FN_DIV, 32'd7, -32'sd2, 0);
    issue(FN_DIV, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    issue(FN_DIV, 32'd100, 32'd7, 0);
    // R6 unsigned divide
    issue(FN_DIVU, 32'hFFFF_FFFF, 32'd2, 0);
    issue(FN_DIVU, 32'd5, 32'd10, 0);
    // R7 divide by zero
    issue(FN_DIV, -32'sd9, 32'd0, 0);
    issue(FN_DIVU, 32'd123, 32'd0, 0);

    // R8: idle readback and unknown read code
    idle_read(FN_MFHI, last_hi, "R8 HI read");
    idle_read(FN_MFLO, last_lo, "R8 LO read");
    idle_read(6'b010001, 32'h0, "R8 unknown code");

    // R10: start during busy ignored
    issue(FN_DIV, -32'sd1000, 32'd33, 1);

    // R11: non-arithmetic start while idle ignored
    @(negedge clk);
    op_start = 1'b1; op_code = FN_MFHI; op_a = 32'd3; op_b = 32'd4;
    @(negedge clk);
    op_start = 1'b0;
    #0.5;
    check(op_busy == 0, "R11 busy stays low", 64'(op_busy), 0);
    idle_read(FN_MFHI, last_hi, "R11 HI kept");
    idle_read(FN_MFLO, last_lo, "R11 LO kept");

    // Mixed operand patterns
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      logic [5:0]  c;
      a = $urandom();
      b = (i % 6 == 5) ? 32'd0 : ((i % 3 == 0) ? ($urandom() >> (i % 29)) : $urandom());
      case (i % 4)
        0: c = FN_MULT;
        1: c = FN_MULTU;
        2: c = FN_DIV;
        default: c = FN_DIVU;
      endcase
      issue(c, a, b, (i % 7) == 3);
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule